// File: doc/BRIEF.md
# Predicate Indirection Table

This block decides which predicate mask applies to a register operand. Configuration arrives as sixteen small records, each written through a register-style write port. A record names a register class (integer or floating point) and a register number to be predicated. It also names the integer register that holds the mask, and carries an invert bit and a zeroing bit. From these records the block builds two per-register lookup tables, one for each class, with 32 slots each.

An issue stage presents a class and a register number on the lookup port. If the table slot is enabled, the block drives a read address to the integer register file. It returns the data that comes back as the mask, complemented when the invert bit is set, and reports the zeroing bit. A slot that no record enabled yields a mask of all ones.

The tables are rebuilt by a small state machine with two states. IDLE holds the tables steady and answers lookups. APPLY clears nothing: it copies one record per cycle into the tables, in ascending record index. The transitions are:

- IDLE to APPLY on any record write. The same write clears both tables.
- APPLY to APPLY while records remain. A new write also stays in APPLY: it clears the tables again and restarts at record 0.
- APPLY to IDLE after the last record is applied with no write pending.

Lookups are held off (not acknowledged) while APPLY is active.

Top module: `pred_map_unit`

## Requirements
- R1: After reset `busy` is low. Every acknowledged lookup then returns an all-ones mask, with `lk_hit` and `lk_zero` low.
- R2: A write stores `cfg_wdata` into record `cfg_idx`. The record fields are: bit 12 class (0 integer, 1 floating point), bits 11:7 the predicated register, bits 6:2 the integer register holding the mask, bit 1 invert, bit 0 zeroing.
- R3: After a write, `busy` is high for exactly 16 cycles, starting in the cycle after the write edge. `lk_ack` stays low whenever `busy` is high.
- R4: Both tables are emptied on every write before any record is applied. A lookup on a slot named by no record returns all ones, with hit and zero low.
- R5: Records are applied in ascending index. When two records share the same class and register, the one with the higher index decides the result.
- R6: For an enabled slot, `rf_raddr` equals the record's mask-register field. The mask comes from `rf_rdata`, for lookups of both classes.
- R7: When the invert bit is set, the mask is the bitwise complement of `rf_rdata`. Otherwise it equals `rf_rdata`.
- R8: `lk_zero` equals the record's zeroing bit on an acknowledged hit, and is low otherwise.
- R9: The integer and floating-point tables are independent. A record of one class never affects lookups of the other class.
- R10: A write that arrives during a rebuild restarts it. `busy` then stays high for 16 cycles after the last write, and the final tables reflect all records.
- R11: The lookup result is combinational. `lk_mask` follows a change of `rf_rdata` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Record write strobe |
| cfg_idx | input | 4 | Record index to write |
| cfg_wdata | input | 13 | Record contents |
| busy | output | 1 | Table rebuild in progress |
| lk_valid | input | 1 | Lookup request |
| lk_cls | input | 1 | Lookup class, 0 integer, 1 floating point |
| lk_reg | input | 5 | Register number looked up |
| lk_ack | output | 1 | Lookup accepted (valid and not busy) |
| lk_hit | output | 1 | Slot is enabled |
| lk_mask | output | 32 | Predicate mask |
| lk_zero | output | 1 | Zero non-predicated elements |
| rf_raddr | output | 5 | Integer register file read address |
| rf_rdata | input | 32 | Integer register file read data |

## Verification
The bench goes after key collisions, both within one class and across classes. A design that applied records in descending order, or merged the two classes, would return the wrong mask-register data. It also checks that the tables are emptied when a record is changed to name another key. A design without the clear would keep a stale slot enabled and report a hit with old data. Writes are issued in the middle of a rebuild: a design that did not restart would drop busy early, or leave out the late record. Busy is counted cycle by cycle, and lookups are attempted during the rebuild, so an off-by-one rebuild length or a lookup accepted too early shows up at the ports.

// File: rtl/pred_map_pkg.sv
package pred_map_pkg;
    localparam int REG_IDX_W = 5;
    localparam int NUM_REGS  = 1 << REG_IDX_W;
    localparam int NUM_CLS   = 2;

    typedef struct packed {
        logic                 cls;
        logic [REG_IDX_W-1:0] key;
        logic [REG_IDX_W-1:0] src;
        logic                 inv;
        logic                 zero;
    } cfg_rec_t;

    typedef struct packed {
        logic                 en;
        logic [REG_IDX_W-1:0] src;
        logic                 inv;
        logic                 zero;
    } slot_t;

    localparam int CFG_W = $bits(cfg_rec_t);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } rb_state_t;
endpackage

// File: rtl/pred_cfg_bank.sv
module pred_cfg_bank
    import pred_map_pkg::*;
#(
    parameter int NUM_CFG = 16,
    localparam int IDX_W  = $clog2(NUM_CFG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  cfg_rec_t         wdata,
    input  logic [IDX_W-1:0] ridx,
    output cfg_rec_t         rdata
);
    cfg_rec_t recs_q [NUM_CFG];

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_rec
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                recs_q[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                recs_q[g] <= wdata;
            end
        end
    end

    assign rdata = recs_q[ridx];
endmodule

// File: rtl/pred_rebuild_fsm.sv
module pred_rebuild_fsm
    import pred_map_pkg::*;
#(
    parameter int NUM_CFG = 16,
    localparam int IDX_W  = $clog2(NUM_CFG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    output logic             busy,
    output logic             apply_en,
    output logic             clear,
    output logic [IDX_W-1:0] step_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CFG - 1);

    rb_state_t state_q, state_d;
    logic      at_last;

    assign at_last = (step_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cfg_we) state_d = ST_APPLY;
            ST_APPLY: if (!cfg_we && at_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b0;
        apply_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin busy = 1'b0; apply_en = 1'b0; end
            ST_APPLY: begin busy = 1'b1; apply_en = !cfg_we; end
            default:  begin busy = 1'b0; apply_en = 1'b0; end
        endcase
        clear = cfg_we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || cfg_we) begin
            step_idx <= '0;
        end else if (state_q == ST_APPLY) begin
            step_idx <= at_last ? '0 : step_idx + 1'b1;
        end
    end
endmodule

// File: rtl/pred_slot_table.sv
module pred_slot_table
    import pred_map_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 apply_en,
    input  cfg_rec_t             apply_rec,
    input  logic                 rd_cls,
    input  logic [REG_IDX_W-1:0] rd_reg,
    output slot_t                rd_slot
);
    slot_t slots_q [NUM_CLS][NUM_REGS];
    slot_t cls_out [NUM_CLS];

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                for (int r = 0; r < NUM_REGS; r++) slots_q[c][r] <= '0;
            end else if (apply_en && (apply_rec.cls == 1'(c))) begin
                slots_q[c][apply_rec.key] <= '{en:   1'b1,
                                               src:  apply_rec.src,
                                               inv:  apply_rec.inv,
                                               zero: apply_rec.zero};
            end
        end
        assign cls_out[c] = slots_q[c][rd_reg];
    end

    assign rd_slot = cls_out[rd_cls];
endmodule

// File: rtl/pred_lookup.sv
module pred_lookup
    import pred_map_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 lk_valid,
    input  logic                 busy,
    input  slot_t                slot,
    input  logic [XLEN-1:0]      rf_rdata,
    output logic [REG_IDX_W-1:0] rf_raddr,
    output logic                 lk_ack,
    output logic                 lk_hit,
    output logic [XLEN-1:0]      lk_mask,
    output logic                 lk_zero
);
    assign rf_raddr = slot.src;
    assign lk_ack   = lk_valid && !busy;
    assign lk_hit   = lk_ack && slot.en;
    assign lk_zero  = lk_hit && slot.zero;

    always_comb begin
        if (!lk_hit)       lk_mask = '1;
        else if (slot.inv) lk_mask = ~rf_rdata;
        else               lk_mask = rf_rdata;
    end
endmodule

// File: rtl/pred_map_unit.sv
module pred_map_unit
    import pred_map_pkg::*;
#(
    parameter int NUM_CFG = 16,
    parameter int XLEN    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_CFG)-1:0] cfg_idx,
    input  logic [CFG_W-1:0]           cfg_wdata,
    output logic                       busy,
    input  logic                       lk_valid,
    input  logic                       lk_cls,
    input  logic [REG_IDX_W-1:0]       lk_reg,
    output logic                       lk_ack,
    output logic                       lk_hit,
    output logic [XLEN-1:0]            lk_mask,
    output logic                       lk_zero,
    output logic [REG_IDX_W-1:0]       rf_raddr,
    input  logic [XLEN-1:0]            rf_rdata
);
    localparam int IDX_W = $clog2(NUM_CFG);

    logic             apply_en;
    logic             clear;
    logic [IDX_W-1:0] step_idx;
    cfg_rec_t         step_rec;
    slot_t            slot;

    pred_cfg_bank #(.NUM_CFG(NUM_CFG)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .widx  (cfg_idx),
        .wdata (cfg_rec_t'(cfg_wdata)),
        .ridx  (step_idx),
        .rdata (step_rec)
    );

    pred_rebuild_fsm #(.NUM_CFG(NUM_CFG)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .busy     (busy),
        .apply_en (apply_en),
        .clear    (clear),
        .step_idx (step_idx)
    );

    pred_slot_table u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .apply_en  (apply_en),
        .apply_rec (step_rec),
        .rd_cls    (lk_cls),
        .rd_reg    (lk_reg),
        .rd_slot   (slot)
    );

    pred_lookup #(.XLEN(XLEN)) u_lk (
        .lk_valid (lk_valid),
        .busy     (busy),
        .slot     (slot),
        .rf_rdata (rf_rdata),
        .rf_raddr (rf_raddr),
        .lk_ack   (lk_ack),
        .lk_hit   (lk_hit),
        .lk_mask  (lk_mask),
        .lk_zero  (lk_zero)
    );
endmodule

// File: rtl/pred_map_unit_chk.sv
module pred_map_unit_chk #(
    parameter int NUM_CFG = 16,
    parameter int XLEN    = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            busy,
    input logic            lk_valid,
    input logic            lk_ack,
    input logic            lk_hit,
    input logic [XLEN-1:0] lk_mask,
    input logic            lk_zero,
    input logic [XLEN-1:0] rf_rdata
);
    int unsigned run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || cfg_we) run_cnt <= 0;
        else if (busy)        run_cnt <= run_cnt + 1;
    end

    a_r3_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> busy);

    a_r3_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lk_ack);

    a_r3_ack_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !busy) |-> lk_ack);

    a_r3_rebuild_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(cfg_we)) |-> (run_cnt == NUM_CFG));

    a_r4_miss_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ack && !lk_hit) |-> (lk_mask == '1));

    a_r8_zero_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_zero |-> lk_hit);

    a_r7_mask_from_rf: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_mask == rf_rdata || lk_mask == ~rf_rdata));
endmodule

bind pred_map_unit pred_map_unit_chk #(.NUM_CFG(NUM_CFG), .XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .busy     (busy),
    .lk_valid (lk_valid),
    .lk_ack   (lk_ack),
    .lk_hit   (lk_hit),
    .lk_mask  (lk_mask),
    .lk_zero  (lk_zero),
    .rf_rdata (rf_rdata)
);

// File: tb/tb_pred_map_unit.sv
module tb_pred_map_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [12:0] cfg_wdata;
    logic        busy;
    logic        lk_valid;
    logic        lk_cls;
    logic [4:0]  lk_reg;
    logic        lk_ack, lk_hit, lk_zero;
    logic [31:0] lk_mask;
    logic [4:0]  rf_raddr;
    logic [31:0] rf_rdata;

    logic [31:0] rf_mem [32];
    logic [12:0] rec_m  [16];
    bit          built;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    assign rf_rdata = rf_mem[rf_raddr];

    pred_map_unit dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] mkrec(bit cls, int key, int src, bit inv, bit zr);
        return {cls, 5'(key), 5'(src), inv, zr};
    endfunction

    // expected: {hit, zero, src, mask-select}
    task automatic expect_lk(input bit cls, input int rg, output bit hit, output bit zr,
                             output logic [4:0] src, output logic [31:0] mask);
        hit = 0; zr = 0; src = 0; mask = '1;
        if (built) begin
            for (int i = 0; i < 16; i++) begin
                if (rec_m[i][12] == cls && rec_m[i][11:7] == 5'(rg)) begin
                    hit = 1; src = rec_m[i][6:2]; zr = rec_m[i][0];
                    mask = rec_m[i][1] ? ~rf_mem[src] : rf_mem[src];
                end
            end
        end
    endtask

    task automatic do_write(input int idx, input logic [12:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_wdata = d;
        rec_m[idx] = d; built = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
    endtask

    task automatic lookup(input bit cls, input int rg, input string tag);
        bit hit, zr; logic [4:0] src; logic [31:0] mask;
        @(negedge clk);
        lk_valid = 1; lk_cls = cls; lk_reg = 5'(rg);
        #1;
        expect_lk(cls, rg, hit, zr, src, mask);
        chk(lk_ack == 1'b1, {tag, " ack"}, 32'(lk_ack), 1);
        chk(lk_hit == hit, {tag, " hit"}, 32'(lk_hit), 32'(hit));
        chk(lk_mask == mask, {tag, " mask"}, lk_mask, mask);
        chk(lk_zero == zr, {tag, " zero"}, 32'(lk_zero), 32'(zr));
        if (hit) chk(rf_raddr == src, {tag, " raddr"}, 32'(rf_raddr), 32'(src));
        lk_valid = 0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240517));
        for (int r = 0; r < 32; r++) rf_mem[r] = $urandom;
        for (int i = 0; i < 16; i++) rec_m[i] = '0;
        built = 0;
        rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0;
        lk_valid = 0; lk_cls = 0; lk_reg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        #1 chk(busy == 0, "R1 busy", 32'(busy), 0);
        lookup(0, 0, "R1 int0");
        lookup(1, 9, "R1 fp9");

        // R2 R3 R6 R8: int key 5 from x7, zeroing
        do_write(3, mkrec(0, 5, 7, 0, 1));
        #1 chk(busy == 1, "R3 busy rises", 32'(busy), 1);
        lk_valid = 1; lk_cls = 0; lk_reg = 5; #1;
        chk(lk_ack == 0, "R3 stalled", 32'(lk_ack), 0);
        lk_valid = 0;
        wait_idle(n);
        chk(n == 16, "R3 busy length", 32'(n), 16);
        lookup(0, 5, "R6 R8 int5");
        lookup(0, 0, "R4 int0 from zero records");
        lookup(1, 5, "R9 fp5 empty");

        // R7 R9: fp key 5 inverted from x7
        do_write(9, mkrec(1, 5, 7, 1, 0));
        wait_idle(n);
        lookup(1, 5, "R7 fp5 inverted");
        lookup(0, 5, "R9 int5 unchanged");

        // R5: later index wins
        do_write(12, mkrec(0, 5, 10, 1, 0));
        wait_idle(n);
        lookup(0, 5, "R5 int5 later wins");

        // R4: move record 12 away, table cleared
        do_write(12, mkrec(0, 20, 11, 0, 0));
        wait_idle(n);
        lookup(0, 5, "R4 int5 back to record 3");
        lookup(0, 20, "R4 int20 new");
        lookup(0, 6, "R4 int6 miss");

        // R10 restart during rebuild
        do_write(1, mkrec(1, 3, 4, 0, 1));
        repeat (5) @(negedge clk);
        do_write(15, mkrec(1, 3, 8, 0, 0));
        wait_idle(n);
        chk(n == 16, "R10 restart length", 32'(n), 16);
        lookup(1, 3, "R10 fp3 final");

        // R11 combinational follow
        @(negedge clk);
        lk_valid = 1; lk_cls = 0; lk_reg = 5; #1;
        rf_mem[7] = 32'hA5A5_0F0F; #1;
        chk(lk_mask == 32'hA5A5_0F0F, "R11 follows rf", lk_mask, 32'hA5A5_0F0F);
        lk_valid = 0;

        // random records and lookups
        for (int it = 0; it < 40; it++) begin
            do_write($urandom_range(0, 15),
                     mkrec($urandom_range(0, 1), $urandom_range(0, 7),
                           $urandom_range(0, 31), $urandom_range(0, 1), $urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) begin
                repeat ($urandom_range(1, 14)) @(negedge clk);
                do_write($urandom_range(0, 15),
                         mkrec($urandom_range(0, 1), $urandom_range(0, 7),
                               $urandom_range(0, 31), $urandom_range(0, 1), $urandom_range(0, 1)));
            end
            wait_idle(n);
            chk(n == 16, "R3 R10 random busy", 32'(n), 16);
            for (int k = 0; k < 12; k++)
                lookup($urandom_range(0, 1), $urandom_range(0, 9), "R5 R6 R7 R9 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule